// File: doc/BRIEF.md
# Log Page Request Decoder

This block sits in the admin command path of a storage controller. It takes the four command dwords of a log page read and the namespace ID, and checks the request. One cycle later it returns either a completion status or a page number, a byte offset into that page and a byte count. A separate DMA engine uses those three values to move the data. Three pages exist: an error-entry page, a health page and a firmware slot page. The firmware page is all zeros. The error page is a fixed set of 64-byte entries.

The block also holds the state that the health page reports: the current temperature, the temperature threshold and an uptime counter. It serves the health page bytes through a combinational byte read port. When a new threshold is written at or below the current temperature, it raises a health event toward the event queue. When a successful read of the error page or the health page does not set the retain flag, the block sends a clear request for that page's event type to the event queue.

Top module: `log_page_decoder`

## Requirements
- R1: The page identifier is cdw10[7:0] and the retain flag is cdw10[15]. The dword count is {cdw11[15:0], cdw10[31:16]}, and the requested length in bytes is (count + 1) * 4, computed without overflow across the full 32-bit count. The byte offset is {cdw13, cdw12}.
- R2: An offset with bit 1 or bit 0 set returns status 0x02 (invalid field) with dnr_o = 1. This check comes before the page identifier check.
- R3: A page identifier other than 0x01 (error page), 0x02 (health page) or 0x03 (firmware page) returns status 0x09 (invalid log page) with dnr_o = 1.
- R4: An offset larger than the selected page returns status 0x02 with dnr_o = 1, and this includes offsets with any upper-dword bit set. An offset equal to the page size succeeds with a byte count of 0.
- R5: On success (status 0x00, dnr_o = 0), xfer_len_o is the smaller of (page size - offset) and the requested length, and ofs_o echoes the offset. The error page is 256 bytes (4 entries of 64 bytes). The health page and the firmware page are 512 bytes each.
- R6: A health page request whose namespace ID is neither 0 nor 0xFFFFFFFF returns status 0x02 with dnr_o = 1.
- R7: A successful error page read with the retain flag clear pulses clr_valid_o, together with the response, with clr_type_o = 0. The same kind of health page read gives clr_type_o = 1. Firmware page reads, retained reads and failed requests never pulse clr_valid_o.
- R8: rsp_valid_o pulses exactly one cycle after each cmd_valid_i cycle and at no other time.
- R9: After reset the temperature is 0x143, the threshold is 0x14D, uptime hours are 0, and rsp_valid_o, clr_valid_o and evt_valid_o are low.
- R10: In the health page, byte 0 bit 1 is set when threshold <= temperature. Bytes 1 and 2 hold the temperature in little-endian order. All bytes not named in R10 or R11 read as zero.
- R11: Bytes 128 to 131 hold the uptime hours in little-endian order. Hours advance by one every MS_PER_HOUR pulses of ms_tick_i.
- R12: A threshold write with a value at or below the current temperature pulses evt_valid_o one cycle later, with evt_type_o = 1 and evt_info_o = 0x01. A write above the temperature raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command dwords valid this cycle |
| cdw10_i | input | 32 | Command dword 10 |
| cdw11_i | input | 32 | Command dword 11 |
| cdw12_i | input | 32 | Command dword 12 (offset low) |
| cdw13_i | input | 32 | Command dword 13 (offset high) |
| nsid_i | input | 32 | Namespace ID of the command |
| temp_we_i | input | 1 | Load a new temperature |
| temp_i | input | 16 | Temperature value |
| thr_we_i | input | 1 | Load a new threshold |
| thr_i | input | 16 | Threshold value |
| ms_tick_i | input | 1 | One pulse per elapsed millisecond |
| hp_addr_i | input | 9 | Health page byte address |
| hp_data_o | output | 8 | Health page byte at hp_addr_i |
| rsp_valid_o | output | 1 | Response valid |
| status_o | output | 8 | Completion status |
| dnr_o | output | 1 | Do-not-retry flag |
| page_o | output | 2 | Selected page (identifier bits 1:0) |
| ofs_o | output | 10 | Start byte offset within the page |
| xfer_len_o | output | 10 | Bytes to transfer |
| clr_valid_o | output | 1 | Event clear request |
| clr_type_o | output | 3 | Event type to clear |
| evt_valid_o | output | 1 | Threshold event pulse |
| evt_type_o | output | 3 | Event type of the pulse |
| evt_info_o | output | 8 | Event info code |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing;
- that every failure carries do-not-retry;
- that a clear request comes only with a successful read of a clearable page;
- that offset plus count stays inside the selected page;
- that events follow threshold writes and hours advance in single steps.

Only the bench's scenarios can show the rest:
- the exact clipped counts;
- the order of the checks (misaligned before unknown identifier);
- the namespace rule;
- the offset-equals-size boundary;
- the overflow-free length for the largest dword count;
- the health page byte layout, including the warning bit as threshold and temperature change.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  localparam logic [7:0] ST_OK        = 8'h00;
  localparam logic [7:0] ST_BAD_FIELD = 8'h02;
  localparam logic [7:0] ST_BAD_LOG   = 8'h09;

  localparam logic [7:0] LID_ERR    = 8'h01;
  localparam logic [7:0] LID_HEALTH = 8'h02;
  localparam logic [7:0] LID_FW     = 8'h03;

  localparam logic [2:0] EVT_ERR    = 3'd0;
  localparam logic [2:0] EVT_HEALTH = 3'd1;
  localparam logic [7:0] INFO_TEMP_THR = 8'h01;

  localparam int unsigned TEMP_W = 16;
endpackage

// File: rtl/lpd_decode.sv
module lpd_decode
  import lpd_pkg::*;
#(
  parameter int unsigned ERR_ENTRIES     = 4,
  parameter int unsigned ERR_ENTRY_BYTES = 64,
  parameter int unsigned PAGE_BYTES      = 512,
  parameter int unsigned OFS_W           = 10
) (
  input  logic [31:0]      cdw10_i,
  input  logic [31:0]      cdw11_i,
  input  logic [31:0]      cdw12_i,
  input  logic [31:0]      cdw13_i,
  input  logic [31:0]      nsid_i,
  output logic [7:0]       status_o,
  output logic             dnr_o,
  output logic [1:0]       page_o,
  output logic [OFS_W-1:0] ofs_o,
  output logic [OFS_W-1:0] xfer_o,
  output logic             clr_o,
  output logic [2:0]       clr_type_o
);
  localparam int unsigned ERR_BYTES = ERR_ENTRIES * ERR_ENTRY_BYTES;

  logic [7:0]  lid;
  logic        rae;
  logic [31:0] numd;
  logic [35:0] req_len;
  logic [63:0] ofs;
  logic [63:0] size;
  logic [63:0] remain;
  logic [63:0] xfer_full;
  logic        known;
  logic        nsid_ok;
  logic        unused_bits;

  assign lid     = cdw10_i[7:0];
  assign rae     = cdw10_i[15];
  assign numd    = {cdw11_i[15:0], cdw10_i[31:16]};
  assign req_len = ({4'd0, numd} + 36'd1) << 2;
  assign ofs     = {cdw13_i, cdw12_i};
  assign unused_bits = ^{cdw10_i[14:8], cdw11_i[31:16]};

  always_comb begin
    known = 1'b1;
    unique case (lid)
      LID_ERR:    size = 64'(ERR_BYTES);
      LID_HEALTH: size = 64'(PAGE_BYTES);
      LID_FW:     size = 64'(PAGE_BYTES);
      default: begin
        size  = '0;
        known = 1'b0;
      end
    endcase
  end

  assign nsid_ok = (lid != LID_HEALTH) || (nsid_i == 32'h0) || (nsid_i == 32'hFFFF_FFFF);
  assign remain  = size - ofs;

  // check order matters: alignment, identifier, namespace, range
  always_comb begin
    status_o  = ST_OK;
    dnr_o     = 1'b0;
    clr_o     = 1'b0;
    xfer_full = '0;
    if (ofs[1:0] != 2'b00) begin
      status_o = ST_BAD_FIELD;
      dnr_o    = 1'b1;
    end else if (!known) begin
      status_o = ST_BAD_LOG;
      dnr_o    = 1'b1;
    end else if (!nsid_ok || (ofs > size)) begin
      status_o = ST_BAD_FIELD;
      dnr_o    = 1'b1;
    end else begin
      xfer_full = ({28'd0, req_len} < remain) ? {28'd0, req_len} : remain;
      clr_o     = !rae && (lid != LID_FW);
    end
  end

  assign page_o     = lid[1:0];
  assign ofs_o      = OFS_W'(ofs);
  assign xfer_o     = OFS_W'(xfer_full);
  assign clr_type_o = (lid == LID_ERR) ? EVT_ERR : EVT_HEALTH;
endmodule

// File: rtl/lpd_health.sv
module lpd_health
  import lpd_pkg::*;
#(
  parameter logic [15:0] TEMP_RST    = 16'h0143,
  parameter logic [15:0] THR_RST     = 16'h014D,
  parameter int unsigned MS_PER_HOUR = 3600000,
  parameter int unsigned HOURS_W     = 32,
  parameter int unsigned HP_AW       = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              temp_we_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              thr_we_i,
  input  logic [TEMP_W-1:0] thr_i,
  input  logic              ms_tick_i,
  input  logic [HP_AW-1:0]  hp_addr_i,
  output logic [7:0]        hp_data_o,
  output logic              evt_valid_o,
  output logic [2:0]        evt_type_o,
  output logic [7:0]        evt_info_o
);
  localparam int unsigned MS_W        = $clog2(MS_PER_HOUR);
  localparam int unsigned HOURS_BASE  = 128;
  localparam int unsigned HOURS_BYTES = HOURS_W / 8;

  logic [TEMP_W-1:0]  temp_q, thr_q;
  logic [MS_W-1:0]    ms_q;
  logic [HOURS_W-1:0] hours_q;
  logic               evt_q;
  logic               crit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_q  <= TEMP_RST;
      thr_q   <= THR_RST;
      ms_q    <= '0;
      hours_q <= '0;
      evt_q   <= 1'b0;
    end else begin
      if (temp_we_i) temp_q <= temp_i;
      if (thr_we_i)  thr_q  <= thr_i;
      evt_q <= thr_we_i && (thr_i <= temp_q);
      if (ms_tick_i) begin
        if (ms_q == MS_W'(MS_PER_HOUR - 1)) begin
          ms_q    <= '0;
          hours_q <= hours_q + 1'b1;
        end else begin
          ms_q <= ms_q + 1'b1;
        end
      end
    end
  end

  assign crit = (thr_q <= temp_q);

  always_comb begin
    hp_data_o = 8'h00;
    if (hp_addr_i == HP_AW'(0)) begin
      hp_data_o = {6'd0, crit, 1'b0};
    end else if (hp_addr_i == HP_AW'(1)) begin
      hp_data_o = temp_q[7:0];
    end else if (hp_addr_i == HP_AW'(2)) begin
      hp_data_o = temp_q[15:8];
    end else if ((hp_addr_i >= HP_AW'(HOURS_BASE)) &&
                 (hp_addr_i <  HP_AW'(HOURS_BASE + HOURS_BYTES))) begin
      hp_data_o = 8'(hours_q >> (8 * (hp_addr_i - HP_AW'(HOURS_BASE))));
    end
  end

  assign evt_valid_o = evt_q;
  assign evt_type_o  = EVT_HEALTH;
  assign evt_info_o  = INFO_TEMP_THR;

  AST_EVT_AFTER_THR_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> $past(thr_we_i)) else $error("evt without write"); // R12
  AST_HOURS_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hours_q) |-> (hours_q == $past(hours_q) + 1'b1) && $past(ms_tick_i))
    else $error("hours jump"); // R11
endmodule

// File: rtl/log_page_decoder.sv
module log_page_decoder
  import lpd_pkg::*;
#(
  parameter int unsigned ERR_ENTRIES     = 4,
  parameter int unsigned ERR_ENTRY_BYTES = 64,
  parameter int unsigned PAGE_BYTES      = 512,
  parameter int unsigned MS_PER_HOUR     = 3600000,
  parameter logic [15:0] TEMP_RST        = 16'h0143,
  parameter logic [15:0] THR_RST         = 16'h014D,
  localparam int unsigned ERR_BYTES = ERR_ENTRIES * ERR_ENTRY_BYTES,
  localparam int unsigned MAX_BYTES = (ERR_BYTES > PAGE_BYTES) ? ERR_BYTES : PAGE_BYTES,
  localparam int unsigned OFS_W     = $clog2(MAX_BYTES + 1),
  localparam int unsigned HP_AW     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [31:0]       cdw10_i,
  input  logic [31:0]       cdw11_i,
  input  logic [31:0]       cdw12_i,
  input  logic [31:0]       cdw13_i,
  input  logic [31:0]       nsid_i,
  input  logic              temp_we_i,
  input  logic [15:0]       temp_i,
  input  logic              thr_we_i,
  input  logic [15:0]       thr_i,
  input  logic              ms_tick_i,
  input  logic [HP_AW-1:0]  hp_addr_i,
  output logic [7:0]        hp_data_o,
  output logic              rsp_valid_o,
  output logic [7:0]        status_o,
  output logic              dnr_o,
  output logic [1:0]        page_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [OFS_W-1:0]  xfer_len_o,
  output logic              clr_valid_o,
  output logic [2:0]        clr_type_o,
  output logic              evt_valid_o,
  output logic [2:0]        evt_type_o,
  output logic [7:0]        evt_info_o
);
  logic [7:0]       d_status;
  logic             d_dnr, d_clr;
  logic [1:0]       d_page;
  logic [OFS_W-1:0] d_ofs, d_xfer;
  logic [2:0]       d_clr_type;

  lpd_decode #(
    .ERR_ENTRIES(ERR_ENTRIES), .ERR_ENTRY_BYTES(ERR_ENTRY_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)
  ) u_decode (
    .cdw10_i(cdw10_i), .cdw11_i(cdw11_i), .cdw12_i(cdw12_i), .cdw13_i(cdw13_i),
    .nsid_i(nsid_i), .status_o(d_status), .dnr_o(d_dnr), .page_o(d_page),
    .ofs_o(d_ofs), .xfer_o(d_xfer), .clr_o(d_clr), .clr_type_o(d_clr_type)
  );

  lpd_health #(
    .TEMP_RST(TEMP_RST), .THR_RST(THR_RST), .MS_PER_HOUR(MS_PER_HOUR),
    .HOURS_W(32), .HP_AW(HP_AW)
  ) u_health (
    .clk_i(clk_i), .rst_ni(rst_ni), .temp_we_i(temp_we_i), .temp_i(temp_i),
    .thr_we_i(thr_we_i), .thr_i(thr_i), .ms_tick_i(ms_tick_i),
    .hp_addr_i(hp_addr_i), .hp_data_o(hp_data_o), .evt_valid_o(evt_valid_o),
    .evt_type_o(evt_type_o), .evt_info_o(evt_info_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      status_o    <= ST_OK;
      dnr_o       <= 1'b0;
      page_o      <= '0;
      ofs_o       <= '0;
      xfer_len_o  <= '0;
      clr_valid_o <= 1'b0;
      clr_type_o  <= '0;
    end else begin
      rsp_valid_o <= cmd_valid_i;
      clr_valid_o <= cmd_valid_i && d_clr;
      if (cmd_valid_i) begin
        status_o   <= d_status;
        dnr_o      <= d_dnr;
        page_o     <= d_page;
        ofs_o      <= d_ofs;
        xfer_len_o <= d_xfer;
        clr_type_o <= d_clr_type;
      end
    end
  end

  logic [OFS_W:0] page_lim;
  assign page_lim = (page_o == LID_ERR[1:0]) ? (OFS_W+1)'(ERR_BYTES) : (OFS_W+1)'(PAGE_BYTES);

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o) else $error("missing rsp"); // R8
  AST_RSP_ONLY_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(cmd_valid_i)) else $error("stray rsp"); // R8
  AST_FAIL_HAS_DNR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && status_o != ST_OK) |-> dnr_o) else $error("no dnr"); // R2
  AST_CLR_ONLY_ON_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_valid_o |-> (rsp_valid_o && status_o == ST_OK && page_o != LID_FW[1:0]))
    else $error("bad clr"); // R7
  AST_XFER_IN_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && status_o == ST_OK) |-> ({1'b0, ofs_o} + {1'b0, xfer_len_o} <= page_lim))
    else $error("xfer past page"); // R5
endmodule

// File: tb/log_page_decoder_bench.sv
module log_page_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic [31:0] cdw10 = '0, cdw11 = '0, cdw12 = '0, cdw13 = '0, nsid = '0;
  logic        temp_we = 1'b0, thr_we = 1'b0, ms_tick = 1'b0;
  logic [15:0] temp_v = '0, thr_v = '0;
  logic [8:0]  hp_addr = '0;
  logic [7:0]  hp_data, status, evt_info;
  logic        rsp_valid, dnr, clr_valid, evt_valid;
  logic [1:0]  page;
  logic [9:0]  ofs, xfer;
  logic [2:0]  clr_type, evt_type;

  log_page_decoder #(.MS_PER_HOUR(5)) u_log_page_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid),
    .cdw10_i(cdw10), .cdw11_i(cdw11), .cdw12_i(cdw12), .cdw13_i(cdw13), .nsid_i(nsid),
    .temp_we_i(temp_we), .temp_i(temp_v), .thr_we_i(thr_we), .thr_i(thr_v),
    .ms_tick_i(ms_tick), .hp_addr_i(hp_addr), .hp_data_o(hp_data),
    .rsp_valid_o(rsp_valid), .status_o(status), .dnr_o(dnr), .page_o(page),
    .ofs_o(ofs), .xfer_len_o(xfer), .clr_valid_o(clr_valid), .clr_type_o(clr_type),
    .evt_valid_o(evt_valid), .evt_type_o(evt_type), .evt_info_o(evt_info)
  );

  typedef struct {
    logic [7:0] st;
    logic       dnr;
    logic [9:0] ofs;
    logic [9:0] xfer;
    logic       clr;
    logic [2:0] ct;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic exp_t mk(input logic [7:0] st, input logic d, input logic [9:0] o,
                              input logic [9:0] x, input logic c, input logic [2:0] t,
                              input string tag);
    exp_t e;
    e.st = st; e.dnr = d; e.ofs = o; e.xfer = x; e.clr = c; e.ct = t; e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [7:0] lid, input logic rae, input logic [31:0] numd,
                      input logic [63:0] off, input logic [31:0] ns, input exp_t e);
    @(negedge clk);
    cmd_valid = 1'b1;
    cdw10 = {numd[15:0], rae, 7'd0, lid};
    cdw11 = {16'h0, numd[31:16]};
    cdw12 = off[31:0];
    cdw13 = off[63:32];
    nsid  = ns;
    exp_q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // monitor: compare each response against the queued expectation
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected rsp", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(status == e.st, {e.tag, " status"}, status, e.st);
          chk(dnr == e.dnr, {e.tag, " dnr"}, dnr, e.dnr);
          if (e.st == 8'h00) begin
            chk(ofs == e.ofs, {e.tag, " ofs"}, ofs, e.ofs);
            chk(xfer == e.xfer, {e.tag, " xfer"}, xfer, e.xfer);
          end
          chk(clr_valid == e.clr, {e.tag, " clr_valid"}, clr_valid, e.clr);
          if (e.clr) chk(clr_type == e.ct, {e.tag, " clr_type"}, clr_type, e.ct);
        end
      end else if (clr_valid) begin
        chk(1'b0, "R7 clr without rsp", 1, 0);
      end
    end
  end

  task automatic hp_chk(input logic [8:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    hp_addr = a;
    #1;
    chk(hp_data == exp, tag, hp_data, exp);
  endtask

  task automatic thr_write(input logic [15:0] v, input logic exp_evt, input string tag);
    @(negedge clk);
    thr_we = 1'b1; thr_v = v;
    @(negedge clk);
    thr_we = 1'b0;
    #1;
    chk(evt_valid == exp_evt, {tag, " evt_valid"}, evt_valid, exp_evt);
    if (exp_evt) begin
      chk(evt_type == 3'd1, {tag, " evt_type"}, evt_type, 1);
      chk(evt_info == 8'h01, {tag, " evt_info"}, evt_info, 1);
    end
    @(negedge clk);
    chk(evt_valid == 1'b0, {tag, " evt pulse width"}, evt_valid, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && !clr_valid && !evt_valid, "R9 idle outputs", {rsp_valid, clr_valid, evt_valid}, 0);
    hp_chk(9'd1, 8'h43, "R9 temp lo");
    hp_chk(9'd2, 8'h01, "R9 temp hi");
    hp_chk(9'd0, 8'h00, "R9 R10 no warning at reset");
    hp_chk(9'd128, 8'h00, "R9 hours zero");

    send(8'h01, 1'b0, 32'd3, 64'd0, 32'd0, mk(8'h00, 0, 10'd0, 10'd16, 1, 3'd0, "R1 R7 err page"));
    send(8'h01, 1'b1, 32'h0000_FFFF, 64'd64, 32'd0, mk(8'h00, 0, 10'd64, 10'd192, 0, 3'd0, "R5 err clipped retained"));
    send(8'h02, 1'b0, 32'd127, 64'd0, 32'd0, mk(8'h00, 0, 10'd0, 10'd512, 1, 3'd1, "R6 R7 health full"));
    send(8'h02, 1'b0, 32'd3, 64'd0, 32'd5, mk(8'h02, 1, 10'd0, 10'd0, 0, 3'd0, "R6 R7 bad nsid"));
    send(8'h02, 1'b0, 32'd3, 64'd508, 32'hFFFF_FFFF, mk(8'h00, 0, 10'd508, 10'd4, 1, 3'd1, "R5 health tail"));
    send(8'h03, 1'b0, 32'd1, 64'd0, 32'd0, mk(8'h00, 0, 10'd0, 10'd8, 0, 3'd0, "R7 fw no clr"));
    send(8'h07, 1'b0, 32'd1, 64'd0, 32'd0, mk(8'h09, 1, 10'd0, 10'd0, 0, 3'd0, "R3 unknown lid"));
    send(8'h00, 1'b0, 32'd1, 64'd0, 32'd0, mk(8'h09, 1, 10'd0, 10'd0, 0, 3'd0, "R3 lid zero"));
    send(8'h07, 1'b0, 32'd1, 64'd2, 32'd0, mk(8'h02, 1, 10'd0, 10'd0, 0, 3'd0, "R2 misaligned first"));
    send(8'h01, 1'b0, 32'd1, 64'd6, 32'd0, mk(8'h02, 1, 10'd0, 10'd0, 0, 3'd0, "R2 misaligned err"));
    send(8'h01, 1'b0, 32'd0, 64'd256, 32'd0, mk(8'h00, 0, 10'd256, 10'd0, 1, 3'd0, "R4 offset at end"));
    send(8'h01, 1'b0, 32'd0, 64'd260, 32'd0, mk(8'h02, 1, 10'd0, 10'd0, 0, 3'd0, "R4 offset past end"));
    send(8'h02, 1'b0, 32'd0, 64'h1_0000_0000, 32'd0, mk(8'h02, 1, 10'd0, 10'd0, 0, 3'd0, "R4 upper offset"));
    send(8'h03, 1'b1, 32'h0001_0000, 64'd0, 32'd0, mk(8'h00, 0, 10'd0, 10'd512, 0, 3'd0, "R1 upper count"));
    send(8'h03, 1'b0, 32'hFFFF_FFFF, 64'd0, 32'd0, mk(8'h00, 0, 10'd0, 10'd512, 0, 3'd0, "R1 max count"));

    thr_write(16'h0143, 1'b1, "R12 thr at temp");
    hp_chk(9'd0, 8'h02, "R10 warning set");
    thr_write(16'h0200, 1'b0, "R12 thr above temp");
    hp_chk(9'd0, 8'h00, "R10 warning cleared");
    @(negedge clk);
    temp_we = 1'b1; temp_v = 16'h0300;
    @(negedge clk);
    temp_we = 1'b0;
    hp_chk(9'd0, 8'h02, "R10 warning from temp");
    hp_chk(9'd1, 8'h00, "R10 temp lo");
    hp_chk(9'd2, 8'h03, "R10 temp hi");
    hp_chk(9'd300, 8'h00, "R10 unused byte");

    @(negedge clk);
    ms_tick = 1'b1;
    repeat (4) @(negedge clk);
    ms_tick = 1'b0;
    hp_chk(9'd128, 8'h00, "R11 before hour");
    @(negedge clk);
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    hp_chk(9'd128, 8'h01, "R11 one hour");
    hp_chk(9'd129, 8'h00, "R11 hours byte1");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all responses seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule